// File: doc/BRIEF.md
# Link Active-State Power Controller

This block sits beside each serial link port and decides which low-power state the link occupies. Each clock it weighs a 2-bit active-state enable field, the device power state, whether the transmitter has anything to send, link-partner requests to enter L1, and a power-off handshake request. From these it produces the current link state, a one-cycle L1 request to the partner, a one-cycle accept or reject answer to a partner request, and a flag that says whether packets may be sent.

The enable field does two jobs. Bit 0 lets the transmitter drop into L0s on its own after a programmable run of idle cycles. Bit 1 lets the port ask for L1 after a longer idle run and also decides whether a partner's L1 request is accepted or rejected. L0s only covers this port's transmit direction. When software moves the device out of D0, the port goes to L1 whatever the enable field says. The L2/3-ready staging state needs D3hot together with a power-off handshake. Removing main power (D3cold) sends the link to L2 when auxiliary power is present and to L3 when it is not.

Top module: `link_aspm_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `link_state` is L0 (code 0), `tx_allow` is 1 and `tx_l1_req`, `rx_l1_ack` and `rx_l1_nak` are 0.
- R2: With `aspm_ctl`=00 the link never enters L0s (code 1) and `tx_l1_req` never rises. A partner request (`rx_l1_req`) seen in L0 or L0s raises `rx_l1_nak` for one cycle on the next cycle, and the state does not change.
- R3: With `aspm_ctl`=01 in D0, the link moves L0→L0s at the clock edge where `tx_idle` has been 1 for `idle_limit` consecutive edges. It never requests L1, and partner requests are rejected.
- R4: With `aspm_ctl`=10 in D0 the link never enters L0s. After `idle_limit << L1_SHIFT` consecutive idle edges it enters L1 (code 2) and pulses `tx_l1_req` for one cycle. A partner request in L0/L0s is accepted: `rx_l1_ack` pulses and the link enters L1 on the same edge.
- R5: With `aspm_ctl`=11 the link enters L0s at `idle_limit` idle edges and then L1, with a `tx_l1_req` pulse, at `idle_limit << L1_SHIFT` idle edges counted from the same start.
- R6: L0s returns to L0 on the first edge where `tx_idle` is 0. L1 returns to L0 on the first edge where `tx_idle` is 0 and the device is in D0. In any other device state L1 is held.
- R7: A device state of D1, D2 or D3hot (`dev_pwr` 1, 2, 3) moves L0 or L0s to L1 on the next edge for any `aspm_ctl`, without `tx_l1_req`.
- R8: L2/3-ready (code 3) is entered only from L0, L0s or L1 on an edge where `dev_pwr` is D3hot and `pwroff_req` is 1. `pwroff_req` in D0 has no effect.
- R9: On any edge where `dev_pwr` is D3cold (4), from any state, the link goes to L2 (code 4) if `vaux_ok` is 1 and to L3 (code 5) otherwise.
- R10: `tx_allow` is 1 exactly when the link is in L0.
- R11: From L2, L3 or L2/3-ready, a device state of D0 returns the link to L0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aspm_ctl | input | 2 | Bit 0 enables L0s entry, bit 1 enables L1 request and acceptance |
| dev_pwr | input | 3 | Device power state: 0 D0, 1 D1, 2 D2, 3 D3hot, 4 D3cold |
| tx_idle | input | 1 | 1 when no packet is waiting to be sent |
| idle_limit | input | CNT_W | Idle edges needed before L0s entry |
| rx_l1_req | input | 1 | L1 entry request received from the link partner |
| pwroff_req | input | 1 | Power-off handshake request |
| vaux_ok | input | 1 | Auxiliary power present |
| link_state | output | 3 | Current link state: 0 L0, 1 L0s, 2 L1, 3 L2/3-ready, 4 L2, 5 L3 |
| tx_l1_req | output | 1 | One-cycle L1 request sent to the partner |
| rx_l1_ack | output | 1 | One-cycle accept of a partner L1 request |
| rx_l1_nak | output | 1 | One-cycle reject of a partner L1 request |
| tx_allow | output | 1 | Packets may be sent |

## Verification
The embedded properties watch several rules on every cycle. `tx_l1_req` only rises when enable bit 1 was set in D0. Entry into L0s only happens with enable bit 0 set. D3cold always leads to L2 or L3. L2/3-ready is only reached from D3hot with the handshake. Accept and reject never appear together, and every accept lands the link in L1. Only the bench's scenarios can show that the idle thresholds are counted exactly, with the edge of entry landing at `idle_limit` and at `idle_limit << L1_SHIFT`. The same holds for the exit paths from L0s and L1, the behaviour that keeps L1 held outside D0, and the return from the off states.

// File: rtl/aspm_pkg.sv
package aspm_pkg;
  typedef enum logic [2:0] {
    LNK_L0     = 3'd0,
    LNK_L0S    = 3'd1,
    LNK_L1     = 3'd2,
    LNK_L23RDY = 3'd3,
    LNK_L2     = 3'd4,
    LNK_L3     = 3'd5
  } lnk_state_e;

  localparam logic [2:0] PWR_D0     = 3'd0;
  localparam logic [2:0] PWR_D1     = 3'd1;
  localparam logic [2:0] PWR_D2     = 3'd2;
  localparam logic [2:0] PWR_D3HOT  = 3'd3;
  localparam logic [2:0] PWR_D3COLD = 3'd4;
endpackage

// File: rtl/aspm_idle_timer.sv
module aspm_idle_timer #(
  parameter int CNT_W    = 8,
  parameter int L1_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             tx_idle,
  input  logic [CNT_W-1:0] idle_limit,
  output logic             hit_l0s,
  output logic             hit_l1
);
  localparam int RUN_W = CNT_W + L1_SHIFT;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_now;
  logic [RUN_W:0]   l0s_thr;
  logic [RUN_W:0]   l1_thr;

  // run_now counts the current idle edge as well
  assign run_now = {1'b0, run_q} + 1'b1;
  assign l0s_thr = {{(L1_SHIFT + 1){1'b0}}, idle_limit};
  assign l1_thr  = l0s_thr << L1_SHIFT;
  assign hit_l0s = count_en && tx_idle && (run_now >= l0s_thr);
  assign hit_l1  = count_en && tx_idle && (run_now >= l1_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (count_en && tx_idle) begin
      if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/aspm_l1_resp.sv
module aspm_l1_resp (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] aspm_ctl,
  input  logic       dev_is_d0,
  input  logic       link_active,
  input  logic       rx_l1_req,
  output logic       accept_now,
  output logic       l1_ack,
  output logic       l1_nak
);
  logic reject_now;

  assign accept_now = rx_l1_req && link_active && dev_is_d0 && aspm_ctl[1];
  assign reject_now = rx_l1_req && link_active && !aspm_ctl[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_ack <= 1'b0;
      l1_nak <= 1'b0;
    end else begin
      l1_ack <= accept_now;
      l1_nak <= reject_now;
    end
  end

  AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
    !(l1_ack && l1_nak)); // R2
  AST_NAK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (rx_l1_req && link_active && !aspm_ctl[1]) |=> (l1_nak && !l1_ack)); // R2
endmodule

// File: rtl/aspm_state_fsm.sv
module aspm_state_fsm
  import aspm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] aspm_ctl,
  input  logic [2:0] dev_pwr,
  input  logic       tx_idle,
  input  logic       pwroff_req,
  input  logic       vaux_ok,
  input  logic       accept_now,
  input  logic       hit_l0s,
  input  logic       hit_l1,
  output lnk_state_e state_q,
  output logic       tx_l1_req,
  output logic       tx_allow
);
  lnk_state_e nxt;
  logic       self_l1;
  logic       is_d0;
  logic       l23_go;

  assign is_d0  = (dev_pwr == PWR_D0);
  assign l23_go = (dev_pwr == PWR_D3HOT) && pwroff_req;

  always_comb begin
    nxt     = state_q;
    self_l1 = 1'b0;
    if (dev_pwr == PWR_D3COLD) begin
      nxt = vaux_ok ? LNK_L2 : LNK_L3;
    end else begin
      case (state_q)
        LNK_L0, LNK_L0S: begin
          if (l23_go)                                  nxt = LNK_L23RDY;
          else if (!is_d0)                             nxt = LNK_L1;
          else if (accept_now)                         nxt = LNK_L1;
          else if (aspm_ctl[1] && hit_l1) begin
            nxt     = LNK_L1;
            self_l1 = 1'b1;
          end
          else if (state_q == LNK_L0S && !tx_idle)     nxt = LNK_L0;
          else if (state_q == LNK_L0 && aspm_ctl[0] && hit_l0s) nxt = LNK_L0S;
        end
        LNK_L1: begin
          if (l23_go)                nxt = LNK_L23RDY;
          else if (is_d0 && !tx_idle) nxt = LNK_L0;
        end
        LNK_L23RDY: begin
          if (is_d0) nxt = LNK_L0;
        end
        default: nxt = LNK_L0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LNK_L0;
      tx_l1_req <= 1'b0;
      tx_allow  <= 1'b1;
    end else begin
      state_q   <= nxt;
      tx_l1_req <= self_l1;
      tx_allow  <= (nxt == LNK_L0);
    end
  end

  AST_TXREQ_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_l1_req |-> ($past(aspm_ctl[1]) && $past(dev_pwr) == PWR_D0)); // R2
  AST_L0S_GATED: assert property (@(posedge clk) disable iff (rst)
    (state_q == LNK_L0S && $past(state_q) != LNK_L0S) |-> $past(aspm_ctl[0])); // R3
  AST_D3COLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (dev_pwr == PWR_D3COLD) |=> (state_q == LNK_L2 || state_q == LNK_L3)); // R9
  AST_L23_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == LNK_L23RDY && $past(state_q) != LNK_L23RDY)
      |-> ($past(dev_pwr) == PWR_D3HOT && $past(pwroff_req))); // R8
endmodule

// File: rtl/link_aspm_ctrl.sv
module link_aspm_ctrl
  import aspm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int L1_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       aspm_ctl,
  input  logic [2:0]       dev_pwr,
  input  logic             tx_idle,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic             rx_l1_req,
  input  logic             pwroff_req,
  input  logic             vaux_ok,
  output logic [2:0]       link_state,
  output logic             tx_l1_req,
  output logic             rx_l1_ack,
  output logic             rx_l1_nak,
  output logic             tx_allow
);
  lnk_state_e state_w;
  logic       active_w;
  logic       d0_w;
  logic       accept_w;
  logic       hit_l0s_w;
  logic       hit_l1_w;

  assign active_w   = (state_w == LNK_L0) || (state_w == LNK_L0S);
  assign d0_w       = (dev_pwr == PWR_D0);
  assign link_state = state_w;

  aspm_idle_timer #(.CNT_W(CNT_W), .L1_SHIFT(L1_SHIFT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .count_en   (active_w && d0_w),
    .tx_idle    (tx_idle),
    .idle_limit (idle_limit),
    .hit_l0s    (hit_l0s_w),
    .hit_l1     (hit_l1_w)
  );

  aspm_l1_resp u_resp (
    .clk         (clk),
    .rst         (rst),
    .aspm_ctl    (aspm_ctl),
    .dev_is_d0   (d0_w),
    .link_active (active_w),
    .rx_l1_req   (rx_l1_req),
    .accept_now  (accept_w),
    .l1_ack      (rx_l1_ack),
    .l1_nak      (rx_l1_nak)
  );

  aspm_state_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .aspm_ctl   (aspm_ctl),
    .dev_pwr    (dev_pwr),
    .tx_idle    (tx_idle),
    .pwroff_req (pwroff_req),
    .vaux_ok    (vaux_ok),
    .accept_now (accept_w),
    .hit_l0s    (hit_l0s_w),
    .hit_l1     (hit_l1_w),
    .state_q    (state_w),
    .tx_l1_req  (tx_l1_req),
    .tx_allow   (tx_allow)
  );

  AST_ACK_IN_L1: assert property (@(posedge clk) disable iff (rst)
    rx_l1_ack |-> (link_state == 3'd2)); // R4
  AST_REQ_IN_L1: assert property (@(posedge clk) disable iff (rst)
    tx_l1_req |-> (link_state == 3'd2 && !rx_l1_ack)); // R5
endmodule

// File: tb/tb_link_aspm_ctrl.sv
module tb_link_aspm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  typedef struct packed {
    logic [1:0] ctl;
    logic [2:0] dev;
    logic       idle;
    logic       rx;
    logic       poff;
    logic       vaux;
    logic [7:0] steps;
    logic [2:0] st;
    logic       txr;
    logic       ack;
    logic       nak;
    logic       alw;
    logic [3:0] req;
  } vec_t;

  // state codes: 0 L0, 1 L0s, 2 L1, 3 L2/3-ready, 4 L2, 5 L3; idle_limit = 4, L1 threshold 16
  localparam vec_t VEC [NV] = '{
    '{2'b00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd20, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 no L0s
    '{2'b00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 reject
    '{2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
    '{2'b01, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 one short
    '{2'b01, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 enter, R10
    '{2'b01, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd20, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 no L1
    '{2'b01, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 reject
    '{2'b01, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 L0s exit
    '{2'b10, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd15, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 no L0s
    '{2'b10, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 L1 + req
    '{2'b10, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 pulse ends
    '{2'b10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 L1 exit
    '{2'b10, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 accept
    '{2'b10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{2'b11, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 L0s
    '{2'b11, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd11, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 one short
    '{2'b11, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 L1
    '{2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{2'b11, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 D2
    '{2'b11, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 D3hot held
    '{2'b11, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1,  3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 handshake
    '{2'b11, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 L2
    '{2'b11, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 L3
    '{2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11}, // R11
    '{2'b11, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 ignored in D0
    '{2'b00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ctl 00
    '{2'b00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 held outside D0
    '{2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] aspm_ctl = 2'b00;
  logic [2:0] dev_pwr = 3'd0;
  logic       tx_idle = 1'b0;
  logic [7:0] idle_limit = 8'd4;
  logic       rx_l1_req = 1'b0;
  logic       pwroff_req = 1'b0;
  logic       vaux_ok = 1'b0;
  logic [2:0] link_state;
  logic       tx_l1_req, rx_l1_ack, rx_l1_nak, tx_allow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_aspm_ctrl dut (
    .clk        (clk),
    .rst        (rst),
    .aspm_ctl   (aspm_ctl),
    .dev_pwr    (dev_pwr),
    .tx_idle    (tx_idle),
    .idle_limit (idle_limit),
    .rx_l1_req  (rx_l1_req),
    .pwroff_req (pwroff_req),
    .vaux_ok    (vaux_ok),
    .link_state (link_state),
    .tx_l1_req  (tx_l1_req),
    .rx_l1_ack  (rx_l1_ack),
    .rx_l1_nak  (rx_l1_nak),
    .tx_allow   (tx_allow)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input int req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input int req, input int st, input int txr, input int ack,
                         input int nak, input int alw);
    chk("link_state", req, int'(link_state), st);
    chk("tx_l1_req",  req, int'(tx_l1_req),  txr);
    chk("rx_l1_ack",  req, int'(rx_l1_ack),  ack);
    chk("rx_l1_nak",  req, int'(rx_l1_nak),  nak);
    chk("tx_allow",   req, int'(tx_allow),   alw);
  endtask

  initial begin
    step(3);
    chk_all(1, 0, 0, 0, 0, 1);  // R1 during reset
    rst = 1'b0;
    step(1);
    chk_all(1, 0, 0, 0, 0, 1);  // R1 first cycle out of reset

    for (int i = 0; i < NV; i++) begin
      aspm_ctl   = VEC[i].ctl;
      dev_pwr    = VEC[i].dev;
      tx_idle    = VEC[i].idle;
      rx_l1_req  = VEC[i].rx;
      pwroff_req = VEC[i].poff;
      vaux_ok    = VEC[i].vaux;
      step(int'(VEC[i].steps));
      chk_all(int'(VEC[i].req), int'(VEC[i].st), int'(VEC[i].txr), int'(VEC[i].ack),
              int'(VEC[i].nak), int'(VEC[i].alw));
    end

    // R9: D3cold straight from L0s
    aspm_ctl = 2'b01; tx_idle = 1'b1;
    step(4);
    chk("L0s before power removal", 3, int'(link_state), 1);
    dev_pwr = 3'd4; vaux_ok = 1'b1;
    step(1);
    chk("L0s to L2", 9, int'(link_state), 4);
    dev_pwr = 3'd0; tx_idle = 1'b0;
    step(1);
    chk("L2 back to L0", 11, int'(link_state), 0);

    // R1: reset taken while in L0s
    tx_idle = 1'b1;
    step(4);
    chk("L0s before reset", 3, int'(link_state), 1);
    rst = 1'b1;
    step(1);
    chk("state after reset", 1, int'(link_state), 0);
    chk("tx_allow after reset", 1, int'(tx_allow), 1);
    rst = 1'b0; tx_idle = 1'b0;
    step(1);

    // R3: smallest threshold, one idle edge
    idle_limit = 8'd1; tx_idle = 1'b1;
    step(1);
    chk("L0s at limit 1", 3, int'(link_state), 1);
    chk("tx_allow in L0s", 10, int'(tx_allow), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule